// File: doc/BRIEF.md
# Watchdog Timer with Feed-Sequence Lock

This block is a bus-mapped watchdog for a processor subsystem. Software loads a 32-bit time-out limit, turns on the interrupt enable (and, if it wants a system reset, the reset enable), and then proves that it is alive by writing a two-byte key to the feed register. The first complete key arms the watchdog. After that the down-counter runs, stepping once every four bus clocks. Each later key reloads the counter from the limit. If the counter reaches zero, the block raises a sticky interrupt flag, sets a time-out flag and, when the reset enable is set, sends a one-clock reset pulse.

Once the watchdog is running, the key is protected. After the first key byte, the next access to any watchdog register must be the second key byte. Any other access counts as a fault and triggers the watchdog as an expiry does. Before the watchdog has been armed, a broken key is dropped without any effect.

The time-out flag is kept through a bus reset, so that software can find out after a restart that the watchdog caused it. Only a power-on reset clears it, or a write of 0 to its bit.

Two state machines carry the control. The key tracker has three states. In FEED_IDLE, a first-key write moves it to FEED_ARMED. In FEED_ARMED, a second-key write returns it to FEED_IDLE and produces a feed. Any other access from FEED_ARMED returns it to FEED_IDLE when the watchdog is halted, or moves it to FEED_FAULT when the watchdog is active. FEED_FAULT lasts one clock and always returns to FEED_IDLE. The run controller has two states: WD_HALTED moves to WD_ACTIVE when a feed completes while the interrupt enable is set, and WD_ACTIVE is left only by a reset.

Top module: `wdog_feedlock`

## Requirements
- R1: Register offsets are 0x0 (mode), 0x4 (limit), 0x8 (feed) and 0xC (count), selected by address bits [3:2]. After a reset by both `por_n` and `bus_rst_n`:
  - mode reads 0;
  - limit reads 0x000000FF;
  - count reads 0x000000FF;
  - `irq` is 0;
  - `wdt_rst` is 0.
- R2: A write to the limit register stores the written value if it is 0xFF or more, and stores 0xFF otherwise. The limit reads back in the same cycle as the read.
- R3: The mode register reads bit0 = interrupt enable, bit1 = reset enable, bit2 = time-out flag, bit3 = interrupt flag, and 0 in all other bits. Writing 1 to bit0 or bit1 sets that bit, and writing 0 to either has no effect. Writes never change bit3.
- R4: A write of 0xAA followed by a write of 0x55 to the feed register loads the counter from the limit. Only `wdata[7:0]` is compared. A count read in the clock after the second write returns the limit, or the limit minus 1 if the watchdog is active.
- R5: The watchdog becomes active only when a feed completes while the interrupt enable is set. Setting the enable alone does not start it. While halted, the count does not change. While active, the count drops by exactly 1 every 4 clocks.
- R6: While active with limit C, `irq` rises between 4C−3 and 4C clocks after the clock edge that took the second feed write. At that point the count reads 0, mode bits 2 and 3 are set, and `irq` stays high until a bus reset.
- R7: `wdt_rst` is a one-clock pulse issued together with a trigger, and only when the reset enable is set. Without the reset enable it stays 0.
- R8: While active, any access to a watchdog register after a 0xAA feed write, other than a write of 0x55 to the feed register, triggers the watchdog. `irq` stays low one clock after the faulty access and is high from the second clock after it.
- R9: While halted, a broken feed sequence is ignored. There is no `irq` and no reload, and the 0xAA is discarded, so a later lone 0x55 does not reload.
- R10: The time-out flag survives `bus_rst_n`. It is cleared by a mode write with bit2 = 0 and by `por_n`. A mode write with bit2 = 1 leaves it unchanged.
- R11: A read of the feed register returns 0. Writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Synchronous active-low bus reset; clears everything except the time-out flag |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything including the time-out flag |
| addr | input | 4 | Byte address of the register being accessed |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| irq | output | 1 | Sticky interrupt flag |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
Read data comes from a combinational path, so every register check samples `rdata` in the same cycle as its strobe, half a clock after the edge before it.

A fault passes through the registered FEED_FAULT state. The bench therefore checks `irq` low at the first falling edge after the faulty access and high at the second.

Expiry depends on the phase of the free-running prescaler, which the bench does not model. The bench waits 4C−4 clocks from the closing feed edge and expects `irq` low, then waits four more clocks and expects `irq` high.

Count rate is checked with two reads taken exactly 40 clocks apart, which must differ by 10.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [1:0] SEL_MODE  = 2'd0;
    localparam logic [1:0] SEL_LIMIT = 2'd1;
    localparam logic [1:0] SEL_FEED  = 2'd2;
    localparam logic [1:0] SEL_COUNT = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int unsigned MB_IEN  = 0;
    localparam int unsigned MB_REN  = 1;
    localparam int unsigned MB_TOF  = 2;
    localparam int unsigned MB_IFLG = 3;

    typedef enum logic [1:0] {
        FEED_IDLE  = 2'd0,
        FEED_ARMED = 2'd1,
        FEED_FAULT = 2'd2
    } feed_state_e;

    typedef enum logic {
        WD_HALTED = 1'b0,
        WD_ACTIVE = 1'b1
    } wd_state_e;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic srst,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // Two ticks never fall on adjacent clocks (R5)
            assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (srst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
    parameter int unsigned     W    = 32,
    parameter logic [W-1:0]    INIT = W'(255)
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         run,
    output logic [W-1:0] cnt,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            cnt_q <= INIT;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt    = cnt_q;
    assign expire = run && tick && !load && (cnt_q == ONE);

    // Halted counter is frozen unless reloaded (R5)
    assert_frozen_when_halted_R5: assert property (@(posedge clk) disable iff (srst)
        (!run && !load) |=> $stable(cnt_q));

    // Active counter takes exactly one step per tick (R5)
    assert_single_step_R5: assert property (@(posedge clk) disable iff (srst)
        (run && tick && !load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - ONE));

    // Expiry leaves the counter at zero (R6)
    assert_expire_at_zero_R6: assert property (@(posedge clk) disable iff (srst)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_feed_fsm.sv
module wdog_feed_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       srst,
    input  logic       access,
    input  logic       feed_wr,
    input  logic [7:0] key,
    input  logic       running,
    output logic       feed_ok,
    output logic       fault
);
    feed_state_e state_q;
    feed_state_e state_d;

    logic first_key;
    logic second_key;

    assign first_key  = feed_wr && (key == KEY_FIRST);
    assign second_key = feed_wr && (key == KEY_SECOND);

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= FEED_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FEED_IDLE: begin
                if (first_key) begin
                    state_d = FEED_ARMED;
                end
            end
            FEED_ARMED: begin
                if (second_key) begin
                    state_d = FEED_IDLE;
                end else if (access) begin
                    state_d = running ? FEED_FAULT : FEED_IDLE;
                end
            end
            FEED_FAULT: begin
                state_d = FEED_IDLE;
            end
            default: begin
                state_d = FEED_IDLE;
            end
        endcase
    end

    always_comb begin
        feed_ok = (state_q == FEED_ARMED) && second_key;
        fault   = (state_q == FEED_FAULT);
    end

    // Fault state only entered from an active watchdog (R8, R9)
    assert_fault_needs_running_R8: assert property (@(posedge clk) disable iff (srst)
        (state_q == FEED_FAULT) |-> $past(running));

    // Fault state lasts exactly one clock (R8)
    assert_fault_one_clock_R8: assert property (@(posedge clk) disable iff (srst)
        (state_q == FEED_FAULT) |=> (state_q == FEED_IDLE));

endmodule

// File: rtl/wdog_feedlock.sv
module wdog_feedlock
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned PRESCALE    = 4,
    parameter int unsigned LIMIT_FLOOR = 255
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wdt_rst
);
    localparam int unsigned       SEL_LSB = 2;
    localparam logic [DATA_W-1:0] FLOOR_V = DATA_W'(LIMIT_FLOOR);

    logic srst;
    assign srst = !bus_rst_n || !por_n;

    logic [1:0] sel;
    logic       unused_addr;
    assign sel         = addr[SEL_LSB +: 2];
    assign unused_addr = ^addr;

    logic access;
    logic mode_wr;
    logic limit_wr;
    logic feed_wr;
    assign access   = wr_en || rd_en;
    assign mode_wr  = wr_en && (sel == SEL_MODE);
    assign limit_wr = wr_en && (sel == SEL_LIMIT);
    assign feed_wr  = wr_en && (sel == SEL_FEED);

    logic              ien_q;
    logic              ren_q;
    logic              tof_q;
    logic              iflg_q;
    logic              pulse_q;
    logic [DATA_W-1:0] limit_q;

    wd_state_e wd_q;
    wd_state_e wd_d;
    logic      running;
    assign running = (wd_q == WD_ACTIVE);

    logic              tick;
    logic              feed_ok;
    logic              fault;
    logic              expire;
    logic              trigger;
    logic [DATA_W-1:0] count;

    wdog_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .srst (srst),
        .tick (tick)
    );

    wdog_feed_fsm u_feed (
        .clk     (clk),
        .srst    (srst),
        .access  (access),
        .feed_wr (feed_wr),
        .key     (wdata[7:0]),
        .running (running),
        .feed_ok (feed_ok),
        .fault   (fault)
    );

    wdog_downcount #(.W(DATA_W), .INIT(FLOOR_V)) u_cnt (
        .clk      (clk),
        .srst     (srst),
        .load     (feed_ok),
        .load_val (limit_q),
        .tick     (tick),
        .run      (running),
        .cnt      (count),
        .expire   (expire)
    );

    assign trigger = expire || fault;

    // Run controller: state register
    always_ff @(posedge clk) begin
        if (srst) begin
            wd_q <= WD_HALTED;
        end else begin
            wd_q <= wd_d;
        end
    end

    // Run controller: next state
    always_comb begin
        wd_d = wd_q;
        unique case (wd_q)
            WD_HALTED: begin
                if (feed_ok && ien_q) begin
                    wd_d = WD_ACTIVE;
                end
            end
            WD_ACTIVE: begin
                wd_d = WD_ACTIVE;
            end
            default: begin
                wd_d = WD_HALTED;
            end
        endcase
    end

    // Mode bits, limit, interrupt flag and reset pulse
    always_ff @(posedge clk) begin
        if (srst) begin
            ien_q   <= 1'b0;
            ren_q   <= 1'b0;
            iflg_q  <= 1'b0;
            pulse_q <= 1'b0;
            limit_q <= FLOOR_V;
        end else begin
            if (mode_wr && wdata[MB_IEN]) begin
                ien_q <= 1'b1;
            end
            if (mode_wr && wdata[MB_REN]) begin
                ren_q <= 1'b1;
            end
            if (trigger) begin
                iflg_q <= 1'b1;
            end
            pulse_q <= trigger && ren_q;
            if (limit_wr) begin
                limit_q <= (wdata < FLOOR_V) ? FLOOR_V : wdata;
            end
        end
    end

    // Time-out flag: only the power-on reset clears it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            tof_q <= 1'b0;
        end else if (trigger) begin
            tof_q <= 1'b1;
        end else if (mode_wr && !wdata[MB_TOF]) begin
            tof_q <= 1'b0;
        end
    end

    // Read mux and outputs
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_MODE: begin
                rdata[MB_IEN]  = ien_q;
                rdata[MB_REN]  = ren_q;
                rdata[MB_TOF]  = tof_q;
                rdata[MB_IFLG] = iflg_q;
            end
            SEL_LIMIT: rdata = limit_q;
            SEL_FEED:  rdata = '0;
            SEL_COUNT: rdata = count;
            default:   rdata = '0;
        endcase
        irq     = iflg_q;
        wdt_rst = pulse_q;
    end

    // Stored limit never below the floor (R2)
    assert_limit_floor_R2: assert property (@(posedge clk) disable iff (srst)
        limit_q >= FLOOR_V);

    // Once active, the watchdog stays active (R5)
    assert_active_sticky_R5: assert property (@(posedge clk) disable iff (srst)
        running |=> running);

    // Interrupt flag is sticky until reset (R6)
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (srst)
        irq |=> irq);

    // Reset pulse only comes with a raised interrupt flag (R7)
    assert_pulse_with_flag_R7: assert property (@(posedge clk) disable iff (srst)
        wdt_rst |-> irq);

    // No trigger of either kind while halted (R9)
    assert_halted_silent_R9: assert property (@(posedge clk) disable iff (srst)
        !running |-> !trigger);

    // Trigger always records the time-out flag (R10)
    assert_tof_recorded_R10: assert property (@(posedge clk) disable iff (srst)
        trigger |=> tof_q);

endmodule

// File: tb/sim_wdog_feedlock.sv
module sim_wdog_feedlock;

    logic        clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        wdt_rst;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    logic [31:0] v;
    logic [31:0] v2;

    always #4 clk = ~clk;

    wdog_feedlock u0 (
        .clk       (clk),
        .bus_rst_n (bus_rst_n),
        .por_n     (por_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq       (irq),
        .wdt_rst   (wdt_rst)
    );

    always @(negedge clk) begin
        if (wdt_rst === 1'b1) pulses++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge; each access takes one clock.
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic feed();
        bus_wr(4'h8, 32'hAA);
        bus_wr(4'h8, 32'h55);
    endtask

    task automatic do_reset(input bit full);
        bus_rst_n = 1'b0;
        if (full) por_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_rst_n = 1'b1;
        por_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lims [8];
        lims = '{32'h0, 32'h1, 32'h7F, 32'hFE, 32'hFF, 32'h100, 32'h12345678, 32'hFFFFFFFF};
        @(negedge clk);
        do_reset(1'b1);

        // R1 reset state
        bus_rd(4'h0, v); chk("R1 mode after reset", v, 32'h0);
        bus_rd(4'h4, v); chk("R1 limit after reset", v, 32'hFF);
        bus_rd(4'hC, v); chk("R1 count after reset", v, 32'hFF);
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 wdt_rst after reset", 32'(wdt_rst), 32'h0);

        // R2 limit clamp sweep
        for (int i = 0; i < 8; i++) begin
            bus_wr(4'h4, lims[i]);
            bus_rd(4'h4, v);
            chk("R2 limit clamp", v, (lims[i] < 32'hFF) ? 32'hFF : lims[i]);
        end

        // R11 feed reads zero, count writes ignored
        bus_rd(4'h8, v); chk("R11 feed reads zero", v, 32'h0);
        bus_wr(4'hC, 32'h1234);
        bus_rd(4'hC, v); chk("R11 count write ignored", v, 32'hFF);

        // R3 set-only and read-only mode bits
        bus_wr(4'h0, 32'h8); bus_rd(4'h0, v); chk("R3 bit3 not writable", v, 32'h0);
        bus_wr(4'h0, 32'h1); bus_rd(4'h0, v); chk("R3 set interrupt enable", v, 32'h1);
        bus_wr(4'h0, 32'h2); bus_rd(4'h0, v); chk("R3 set reset enable", v, 32'h3);
        bus_wr(4'h0, 32'h0); bus_rd(4'h0, v); chk("R3 zero write keeps enables", v, 32'h3);

        // R4 / R5 reload and start conditions
        do_reset(1'b1);
        bus_wr(4'h4, 32'h300);
        feed();
        bus_rd(4'hC, v); chk("R4 halted feed reloads limit", v, 32'h300);
        repeat (40) @(negedge clk);
        bus_rd(4'hC, v); chk("R5 halted count frozen", v, 32'h300);
        bus_wr(4'h0, 32'h1);
        repeat (40) @(negedge clk);
        bus_rd(4'hC, v); chk("R5 enable alone does not start", v, 32'h300);
        feed();
        bus_rd(4'hC, v);
        chk("R4 active feed reload", 32'((v == 32'h300) || (v == 32'h2FF)), 32'h1);
        repeat (39) @(negedge clk);
        bus_rd(4'hC, v2);
        chk("R5 ten steps in forty clocks", v - v2, 32'd10);
        feed();
        bus_rd(4'hC, v);
        chk("R4 refeed while active", 32'((v == 32'h300) || (v == 32'h2FF)), 32'h1);
        chk("R4 refeed raises no irq", 32'(irq), 32'h0);

        // R6 expiry window sweep, R7 no pulse without reset enable
        for (int c = 0; c < 3; c++) begin
            int lim;
            lim = (c == 0) ? 255 : ((c == 1) ? 256 : 321);
            do_reset(1'b1);
            pulses = 0;
            bus_wr(4'h4, 32'(lim));
            bus_wr(4'h0, 32'h1);
            feed();
            repeat (4 * lim - 4) @(negedge clk);
            chk("R6 irq low before window", 32'(irq), 32'h0);
            repeat (4) @(negedge clk);
            chk("R6 irq high after window", 32'(irq), 32'h1);
            bus_rd(4'hC, v); chk("R6 count at zero", v, 32'h0);
            bus_rd(4'h0, v); chk("R6 flags set in mode", v, 32'hD);
            chk("R7 no pulse without reset enable", 32'(pulses), 32'h0);
        end

        // R10 flag survives bus reset, clears on zero write
        do_reset(1'b0);
        bus_rd(4'h0, v); chk("R10 tof survives bus reset", v, 32'h4);
        bus_wr(4'h0, 32'h4); bus_rd(4'h0, v); chk("R10 writing one keeps tof", v, 32'h4);
        bus_wr(4'h0, 32'h0); bus_rd(4'h0, v); chk("R10 writing zero clears tof", v, 32'h0);

        // R7 single pulse with reset enable
        pulses = 0;
        bus_wr(4'h0, 32'h3);
        feed();
        repeat (4 * 255 + 2) @(negedge clk);
        chk("R7 one reset pulse", 32'(pulses), 32'h1);
        bus_rd(4'h0, v); chk("R7 mode after reset expiry", v, 32'hF);
        do_reset(1'b1);
        bus_rd(4'h0, v); chk("R10 power-on reset clears tof", v, 32'h0);

        // R8 faulty access sweep while active
        for (int k = 0; k < 4; k++) begin
            do_reset(1'b0);
            bus_wr(4'h0, (k % 2) ? 32'h3 : 32'h1);
            feed();
            bus_wr(4'h8, 32'hAA);
            case (k)
                0: bus_rd(4'h0, v);
                1: bus_wr(4'h8, 32'h12);
                2: bus_wr(4'h4, 32'h400);
                default: bus_rd(4'hC, v);
            endcase
            chk("R8 irq low one clock after fault", 32'(irq), 32'h0);
            @(negedge clk);
            chk("R8 irq high at second clock", 32'(irq), 32'h1);
            chk("R7 pulse follows reset enable", 32'(wdt_rst), 32'(k % 2));
        end

        // R9 broken sequences ignored while halted
        do_reset(1'b1);
        bus_wr(4'h4, 32'h200);
        bus_wr(4'h0, 32'h1);
        bus_wr(4'h8, 32'hAA);
        bus_rd(4'h0, v);
        repeat (3) @(negedge clk);
        chk("R9 no irq for halted fault", 32'(irq), 32'h0);
        bus_wr(4'h8, 32'hAA);
        bus_wr(4'h8, 32'h12);
        bus_wr(4'h8, 32'h55);
        bus_rd(4'hC, v); chk("R9 discarded key gives no reload", v, 32'hFF);
        feed();
        bus_rd(4'hC, v);
        chk("R9 clean feed then starts", 32'((v == 32'h200) || (v == 32'h1FF)), 32'h1);

        summary();
        $finish;
    end

endmodule